// File: doc/BRIEF.md
# Phase-Encoded Packet Transmitter

This block turns a message of 16-bit words into a Manchester-coded serial stream on a single output line. Words are written into an internal transmit queue. Each word may carry an end-of-message tag, and the tagged word is the last word of the frame. Every frame opens with one sync bit of value 1. The data words follow, most significant bit first and in the order they were loaded. The frame closes with a 16-bit CRC that is accumulated over the data bits as they are shifted out. One bit occupies two system clock cycles, and the line rests low between frames.

A frame starts only when all of these hold: the countdown input reports expiry, no carrier is sensed on the medium, no collision is pending, and the queue is either full or holds a complete message. Loading may continue while a long frame is being sent. The collision input aborts the frame at once. It discards the queued words and latches a collision flag with a one-cycle wakeup pulse, so the controlling logic can reset the interface. If the queue runs dry before the tagged word has been sent, the frame ends with no CRC.

Top module: `pe_frame_tx`

## Requirements
- R1: Each bit takes two clock cycles. A 1 is driven high then low, and a 0 is driven low then high. `line_out` is low whenever `busy` is low.
- R2: Every frame begins with exactly one sync bit of value 1 before the first data bit.
- R3: Data words are sent in load order, each from bit 15 down to bit 0.
- R4: After the bits of the word loaded with `ld_last`=1, the 16-bit CRC is sent from bit 15 down to bit 0. The CRC uses polynomial 0x8005 (x^16+x^15+x^2+1), starts at zero and covers the data bits in sending order.
- R5: At the first clock edge where `cdown_done`=1, `carrier`=0, `coll_flag`=0 and (queue full or a tagged word queued) all hold, the block starts. `busy` is high and the sync bit's first half is on the line in the following cycle.
- R6: No frame ever starts while `carrier` is high.
- R7: A message of fewer than 16 words with no tagged word loaded does not start a frame.
- R8: `busy` is high from the first half of the sync bit through the second half of the last CRC bit, and it falls in the next cycle.
- R9: When `coll_in` is high at a clock edge while `busy` is high, the next cycle has `busy` and `line_out` low, `coll_flag` set and `wake_req` high for exactly one cycle, and all queued words are discarded.
- R10: While `coll_flag` is set, no frame starts. `coll_clr` clears the flag. `coll_in` while idle has no effect.
- R11: If the queue is empty when the next data word is needed and the tagged word has not been sent, the line returns idle and `busy` falls with no CRC sent.
- R12: `ld_ready` is high exactly when the queue (16 words) is not full. Words may be loaded during a frame and are sent in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load a word this cycle (taken when `ld_ready`) |
| ld_data | input | 16 | Word to load |
| ld_last | input | 1 | The loaded word ends the message |
| ld_ready | output | 1 | Queue has room |
| cdown_done | input | 1 | Countdown has reached zero |
| carrier | input | 1 | Carrier sensed on the medium |
| coll_in | input | 1 | Collision indication from the line side |
| coll_clr | input | 1 | Clears the collision flag |
| line_out | output | 1 | Manchester-coded serial output |
| busy | output | 1 | A frame is on the line |
| coll_flag | output | 1 | Latched collision indication |
| wake_req | output | 1 | One-cycle wakeup request on collision |

## Verification
The hardest case to reach from the ports is a queue underrun in the middle of a frame. The stimulus fills the queue to its full depth with untagged words, so that the full condition starts the frame, and then loads nothing more. A second hard case is a frame longer than the queue: that frame is started by the full condition, and more words are loaded in a parallel thread while the frame goes out. To show that a collision discards the queue, the stimulus clears the flag after the abort and checks that no frame starts, even with the countdown expired.

// File: rtl/pe_tx_pkg.sv
package pe_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_DATA = 2'd2,
    ST_CRC  = 2'd3
  } tx_state_e;

  // one serial step of an MSB-first CRC register with zero-based remainder
  function automatic logic [15:0] crc16_step(input logic [15:0] crc_in,
                                             input logic        bit_in,
                                             input logic [15:0] poly);
    logic fb;
    fb = bit_in ^ crc_in[15];
    crc16_step = {crc_in[14:0], 1'b0} ^ (fb ? poly : 16'h0000);
  endfunction

endpackage

// File: rtl/pe_tx_fifo.sv
module pe_tx_fifo #(
  parameter int W     = 17,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  input  logic         flush,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign full    = (cnt == FULL_CNT);
  assign empty   = (cnt == '0);
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == LAST_IDX) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST_IDX) ? '0 : rp + 1'b1;
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  a_r12_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  a_r12_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);

endmodule

// File: rtl/pe_tx_start.sv
module pe_tx_start (
  input  logic clk,
  input  logic rst_n,
  input  logic tagged_push,
  input  logic tagged_pop,
  input  logic flush,
  input  logic fifo_full,
  input  logic cdown_done,
  input  logic carrier,
  input  logic coll_flag,
  input  logic busy,
  output logic start
);
  logic msg_whole;

  // a complete message sits in the queue once its tagged word is written
  always_ff @(posedge clk) begin
    if (!rst_n || flush)  msg_whole <= 1'b0;
    else if (tagged_push) msg_whole <= 1'b1;
    else if (tagged_pop)  msg_whole <= 1'b0;
  end

  assign start = !busy && cdown_done && !carrier && !coll_flag
               && (fifo_full || msg_whole);

  a_r7_start_needs_content: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (fifo_full || $past(tagged_push) || msg_whole));

endmodule

// File: rtl/pe_tx_serial.sv
module pe_tx_serial
  import pe_tx_pkg::*;
#(
  parameter int          DW   = 16,
  parameter logic [15:0] POLY = 16'h8005
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          collision,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_last,
  input  logic          fifo_empty,
  output logic          pop,
  output logic          pop_last,
  output logic          coll_hit,
  output logic          line_out,
  output logic          busy
);
  localparam int BW = $clog2(DW);
  localparam logic [BW-1:0] BIT_MAX = BW'(DW - 1);

  tx_state_e     state;
  logic          half;
  logic [BW-1:0] bitcnt;
  logic [DW-1:0] shreg;
  logic          cur_last;
  logic [15:0]   crc;

  // named internal events
  logic          bit_end, word_end, need_word, underrun, cur_bit;
  logic [15:0]   crc_nxt;

  assign busy      = (state != ST_IDLE);
  assign bit_end   = busy && half;
  assign word_end  = bit_end && (bitcnt == BIT_MAX);
  assign need_word = (state == ST_SYNC && bit_end)
                  || (state == ST_DATA && word_end && !cur_last);
  assign coll_hit  = collision && busy;
  assign underrun  = need_word && fifo_empty && !coll_hit;
  assign pop       = need_word && !fifo_empty && !coll_hit;
  assign pop_last  = pop && rd_last;
  assign crc_nxt   = crc16_step(crc, shreg[DW-1], POLY);

  always_comb begin
    unique case (state)
      ST_SYNC: cur_bit = 1'b1;
      ST_DATA: cur_bit = shreg[DW-1];
      ST_CRC:  cur_bit = crc[15];
      default: cur_bit = 1'b0;
    endcase
  end

  assign line_out = busy && (cur_bit ^ half);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      half     <= 1'b0;
      bitcnt   <= '0;
      shreg    <= '0;
      cur_last <= 1'b0;
      crc      <= '0;
    end else if (coll_hit) begin
      state <= ST_IDLE;
      half  <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (start) begin
        state <= ST_SYNC;
        half  <= 1'b0;
        crc   <= '0;
      end
    end else begin
      half <= ~half;
      if (bit_end) begin
        unique case (state)
          ST_SYNC: begin
            if (underrun) state <= ST_IDLE;
            else begin
              shreg    <= rd_data;
              cur_last <= rd_last;
              bitcnt   <= '0;
              state    <= ST_DATA;
            end
          end
          ST_DATA: begin
            crc <= crc_nxt;
            if (word_end) begin
              bitcnt <= '0;
              if (cur_last)      state <= ST_CRC;
              else if (underrun) state <= ST_IDLE;
              else begin
                shreg    <= rd_data;
                cur_last <= rd_last;
              end
            end else begin
              shreg  <= {shreg[DW-2:0], 1'b0};
              bitcnt <= bitcnt + 1'b1;
            end
          end
          ST_CRC: begin
            crc    <= {crc[14:0], 1'b0};
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == BIT_MAX) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  a_r1_second_half_inverts: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && half) |-> (line_out != $past(line_out)));
  a_r2_sync_opens_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> line_out);
  a_r11_underrun_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !busy && !line_out);
  a_r4_crc_follows_tagged_word: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && word_end && cur_last && !coll_hit) |=> (state == ST_CRC));

endmodule

// File: rtl/pe_frame_tx.sv
module pe_frame_tx #(
  parameter int          DW    = 16,
  parameter int          DEPTH = 16,
  parameter logic [15:0] POLY  = 16'h8005
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic [DW-1:0] ld_data,
  input  logic          ld_last,
  output logic          ld_ready,
  input  logic          cdown_done,
  input  logic          carrier,
  input  logic          coll_in,
  input  logic          coll_clr,
  output logic          line_out,
  output logic          busy,
  output logic          coll_flag,
  output logic          wake_req
);
  localparam int QW = DW + 1;

  logic          push, pop, pop_last, coll_hit, start;
  logic          q_full, q_empty;
  logic [QW-1:0] q_rd;

  assign ld_ready = !q_full;
  assign push     = ld_valid && ld_ready;

  pe_tx_fifo #(.W(QW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data ({ld_last, ld_data}),
    .pop       (pop),
    .flush     (coll_hit),
    .rd_data   (q_rd),
    .full      (q_full),
    .empty     (q_empty)
  );

  pe_tx_start u_start (
    .clk         (clk),
    .rst_n       (rst_n),
    .tagged_push (push && ld_last),
    .tagged_pop  (pop_last),
    .flush       (coll_hit),
    .fifo_full   (q_full),
    .cdown_done  (cdown_done),
    .carrier     (carrier),
    .coll_flag   (coll_flag),
    .busy        (busy),
    .start       (start)
  );

  pe_tx_serial #(.DW(DW), .POLY(POLY)) u_serial (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .collision  (coll_in),
    .rd_data    (q_rd[DW-1:0]),
    .rd_last    (q_rd[DW]),
    .fifo_empty (q_empty),
    .pop        (pop),
    .pop_last   (pop_last),
    .coll_hit   (coll_hit),
    .line_out   (line_out),
    .busy       (busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coll_flag <= 1'b0;
      wake_req  <= 1'b0;
    end else begin
      wake_req <= coll_hit;
      if (coll_hit)      coll_flag <= 1'b1;
      else if (coll_clr) coll_flag <= 1'b0;
    end
  end

  a_r6_no_start_under_carrier: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!$past(carrier) && $past(cdown_done)));
  a_r9_collision_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_in && busy) |=> (!busy && !line_out && coll_flag && wake_req));
  a_r10_flag_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    $past(coll_flag) |-> !$rose(busy));
  a_r1_idle_line_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !line_out);

endmodule

// File: tb/pe_frame_tx_bench.sv
module pe_frame_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [15:0] ld_data = '0;
  logic        ld_last = 1'b0;
  logic        ld_ready;
  logic        cdown_done = 1'b0;
  logic        carrier = 1'b0;
  logic        coll_in = 1'b0;
  logic        coll_clr = 1'b0;
  logic        line_out, busy, coll_flag, wake_req;

  int checks = 0;
  int errors = 0;
  logic [15:0] msg [32];
  logic        exp_bits [600];

  pe_frame_tx u_pe_frame_tx (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_data(ld_data),
    .ld_last(ld_last), .ld_ready(ld_ready), .cdown_done(cdown_done),
    .carrier(carrier), .coll_in(coll_in), .coll_clr(coll_clr),
    .line_out(line_out), .busy(busy), .coll_flag(coll_flag), .wake_req(wake_req)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // CRC as a polynomial remainder of message * x^16 over 0x18005
  function automatic logic [15:0] ref_crc(input int nw);
    logic [16:0] r;
    r = '0;
    for (int i = 0; i < nw * 16 + 16; i++) begin
      logic b;
      b = (i < nw * 16) ? msg[i / 16][15 - (i % 16)] : 1'b0;
      r = {r[15:0], b};
      if (r[16]) r = r ^ 17'h18005;
    end
    return r[15:0];
  endfunction

  function automatic int build_bits(input int nw, input bit with_crc);
    int n;
    logic [15:0] c;
    n = 0;
    exp_bits[n++] = 1'b1;
    for (int w = 0; w < nw; w++)
      for (int b = 15; b >= 0; b--) exp_bits[n++] = msg[w][b];
    if (with_crc) begin
      c = ref_crc(nw);
      for (int b = 15; b >= 0; b--) exp_bits[n++] = c[b];
    end
    return n;
  endfunction

  task automatic push(input logic [15:0] d, input logic last);
    @(negedge clk);
    while (!ld_ready) @(negedge clk);
    ld_valid = 1'b1; ld_data = d; ld_last = last;
    @(negedge clk);
    ld_valid = 1'b0; ld_last = 1'b0;
  endtask

  task automatic idle_no_start(input int n, input string req);
    int seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy || line_out) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  // R1 R2 R3 R4 R8: whole line waveform of one frame
  task automatic check_frame(input int nw, input bit with_crc, input string tag);
    int nb, guard, bad, first;
    logic got, want;
    nb = build_bits(nw, with_crc);
    guard = 0;
    while (!busy && guard < 300) begin @(negedge clk); guard++; end
    cdown_done = 1'b0;
    check(busy == 1'b1, {tag, " R5 frame start"}, busy, 1);
    bad = 0; first = -1; got = 0; want = 0;
    for (int i = 0; i < nb; i++) begin
      for (int h = 0; h < 2; h++) begin
        if (line_out !== (exp_bits[i] ^ h[0]) || busy !== 1'b1) begin
          if (first < 0) begin first = i * 2 + h; got = line_out; want = exp_bits[i] ^ h[0]; end
          bad++;
        end
        @(negedge clk);
      end
    end
    if (bad != 0)
      $display("  %s first mismatch at half %0d line=%0d", tag, first, got);
    check(bad == 0, {tag, " R1 R2 R3 R4 waveform"}, got, want);
    check(!busy && !line_out, {tag, " R8 busy falls after last bit"}, busy, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !line_out && !coll_flag && !wake_req && ld_ready,
          "R1 R12 reset state", busy, 0);

    // R7: partial message without tag never starts
    for (int i = 0; i < 6; i++) msg[i] = 16'hA000 + 16'(i * 16'h0111);
    for (int i = 0; i < 5; i++) push(msg[i], 1'b0);
    cdown_done = 1'b1;
    idle_no_start(12, "R7 partial message held");
    push(msg[5], 1'b1);
    check_frame(6, 1'b1, "tagged completion");

    // R5 R6: carrier holds off start; start one cycle after it drops
    msg[0] = 16'h8001; msg[1] = 16'h0000; msg[2] = 16'hFFFF;
    for (int i = 0; i < 3; i++) push(msg[i], i == 2);
    carrier = 1'b1; cdown_done = 1'b1;
    idle_no_start(15, "R6 carrier blocks start");
    carrier = 1'b0;
    @(negedge clk);
    check(busy && line_out, "R5 start in next cycle", busy, 1);
    check_frame(3, 1'b1, "after carrier");

    // R5: countdown not expired holds start
    msg[0] = 16'h1234;
    push(msg[0], 1'b1);
    idle_no_start(10, "R5 countdown not done");
    cdown_done = 1'b1;
    check_frame(1, 1'b1, "single word");

    // R12: long frame, started by full queue, topped up while sending
    for (int i = 0; i < 20; i++) msg[i] = 16'($urandom);
    for (int i = 0; i < 16; i++) push(msg[i], 1'b0);
    check(ld_ready == 1'b0, "R12 ready low when full", ld_ready, 0);
    cdown_done = 1'b1;
    fork
      check_frame(20, 1'b1, "R12 long frame");
      begin
        for (int i = 16; i < 20; i++) push(msg[i], i == 19);
      end
    join

    // R11: full queue, no tag, nothing more loaded -> underrun, no CRC
    for (int i = 0; i < 16; i++) msg[i] = 16'($urandom);
    for (int i = 0; i < 16; i++) push(msg[i], 1'b0);
    cdown_done = 1'b1;
    check_frame(16, 1'b0, "R11 underrun");
    check(ld_ready == 1'b1, "R11 queue drained", ld_ready, 1);

    // R9 R10: collision during a frame
    for (int i = 0; i < 4; i++) push(16'($urandom), i == 3);
    cdown_done = 1'b1;
    while (!busy) @(negedge clk);
    cdown_done = 1'b0;
    repeat (40) @(negedge clk);
    coll_in = 1'b1;
    @(negedge clk);
    coll_in = 1'b0;
    check(!busy && !line_out, "R9 line idle after collision", busy, 0);
    check(coll_flag && wake_req, "R9 flag and wake set", {coll_flag, wake_req}, 3);
    @(negedge clk);
    check(!wake_req && coll_flag, "R9 wake is one cycle", wake_req, 0);
    cdown_done = 1'b1;
    idle_no_start(12, "R10 flag blocks start");
    coll_clr = 1'b1;
    @(negedge clk);
    coll_clr = 1'b0;
    check(!coll_flag, "R10 clear drops flag", coll_flag, 0);
    idle_no_start(12, "R9 queue discarded");
    cdown_done = 1'b0;
    coll_in = 1'b1;
    @(negedge clk);
    coll_in = 1'b0;
    @(negedge clk);
    check(!coll_flag && !wake_req, "R10 idle collision ignored", coll_flag, 0);

    // random frames
    for (int f = 0; f < 6; f++) begin
      int nw;
      nw = 1 + int'($urandom % 12);
      for (int i = 0; i < nw; i++) msg[i] = 16'($urandom);
      for (int i = 0; i < nw; i++) push(msg[i], i == nw - 1);
      cdown_done = 1'b1;
      check_frame(nw, 1'b1, "random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule